// File: doc/BRIEF.md
# Clock Source Start-up Sequencer

This block keeps a processor core from executing until its supply and its chosen oscillator have both had time to settle. A 4-bit clock-select configuration value is decoded into a source class. Codes in the reserved group are flagged. A configuration bit of 1 is read as unprogrammed and a bit of 0 as programmed, and the decode uses the raw value with that polarity. The run-enable output goes high only after the required delays have been counted.

Reset and wake take different paths. After reset, the sequencer first waits for the supply to settle. This delay is counted in ticks of a free-running watchdog oscillator, either 4,096 or 65,536 of them as a configuration bit selects. It then waits for the selected clock to stabilise, counted in that clock's own ticks, with a separate count for each source class. A wake from deep sleep skips the supply wait and times only the oscillator settling. Both tick inputs are single-cycle-per-tick strobes that are synchronous to the block clock.

Top module: `startup_seq`

## Requirements
- R1: Any select code with bit 3 set (1000 through 1111) decodes to source id 1 (crystal/resonator), with the reserved flag low.
- R2: Codes 0111 and 0110 decode to id 2 (low-frequency crystal). Code 0010 decodes to id 3 (internal RC). Code 0000 decodes to id 4 (external clock). Each of these has the reserved flag low.
- R3: Codes 0001, 0011, 0100 and 0101 raise the reserved flag and give source id 0.
- R4: After reset release, run-enable stays low until wdt_tick has been high on 4,096 clock edges (long_delay=0) or 65,536 edges (long_delay=1). osc_tick has no effect during this phase.
- R5: After the supply phase, run-enable rises at the clock edge on which osc_tick is high for the Nth time. N is 16 for id 1, 32 for id 2, 6 for id 3 and 2 for id 4.
- R6: While the code is reserved, the block stays in its delay phases with run-enable low and counts no ticks. When a valid code appears, the delay count restarts from zero.
- R7: sleep_req high at a clock edge while run-enable is high drops run-enable at that same edge, and it stays low.
- R8: wake_req in the sleep state starts only the oscillator delay of R5. No wdt_tick is needed before run-enable rises again.
- R9: wake_req outside the sleep state has no effect. While running, run-enable stays high.
- R10: rst_n low forces run-enable low at once. After release, the sequence restarts with the supply delay of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on/reset, asynchronous active low |
| clk_sel | input | 4 | Clock-select configuration code (1 = unprogrammed) |
| long_delay | input | 1 | 1 selects the 65,536-tick supply delay, 0 selects 4,096 |
| sleep_req | input | 1 | Enter deep sleep from the running state |
| wake_req | input | 1 | Wake request, honoured only in sleep |
| wdt_tick | input | 1 | Watchdog oscillator tick strobe |
| osc_tick | input | 1 | Selected clock tick strobe |
| src_id | output | 3 | Decoded source class (0 none, 1 crystal, 2 LF crystal, 3 RC, 4 external) |
| sel_reserved | output | 1 | Select code is reserved |
| run_en | output | 1 | Instruction execution enabled |

## Verification
The properties assume that tick strobes and requests are sampled as levels on rising clock edges. They also assume that the select code changes only while the block is in reset, in sleep or in a reserved hold, never partway through a valid delay. The stimulus drives every input on the falling edge. It changes clk_sel only at those safe points, except during the combinational decode sweep, which runs while the core is held in reset. Tick bursts are applied as exact counts of high edges, so every boundary (N-1 versus N) is placed precisely.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_XTAL   = 3'd1,
    SRC_LFXTAL = 3'd2,
    SRC_RCOSC  = 3'd3,
    SRC_EXTCLK = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    ST_RESET_DELAY = 2'd0,
    ST_OSC_DELAY   = 2'd1,
    ST_RUN         = 2'd2,
    ST_SLEEP       = 2'd3
  } seq_st_e;

endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/sel_decode.sv
module sel_decode
  import startup_pkg::*;
(
  input  logic [3:0] code,
  output src_e       src,
  output logic       rsv
);

  // raw value decoded as configured: 1 = unprogrammed, 0 = programmed
  always_comb begin
    src = SRC_NONE;
    rsv = 1'b0;
    casez (code)
      4'b1???: src = SRC_XTAL;
      4'b011?: src = SRC_LFXTAL;
      4'b0010: src = SRC_RCOSC;
      4'b0000: src = SRC_EXTCLK;
      default: rsv = 1'b1;
    endcase
  end

endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] target,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_we;

  assign cnt_we = clr | en;
  assign cnt_d  = clr ? '0 : cnt_q + W'(1);
  assign done   = en & (cnt_q == (target - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import startup_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rsv,
  input  logic    sleep_req,
  input  logic    wake_req,
  input  logic    cnt_done,
  output seq_st_e state,
  output logic    cnt_clr
);

  seq_st_e st_q;
  seq_st_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RESET_DELAY: if (!rsv && cnt_done) st_d = ST_OSC_DELAY;
      ST_OSC_DELAY:   if (!rsv && cnt_done) st_d = ST_RUN;
      ST_RUN:         if (sleep_req)        st_d = ST_SLEEP;
      ST_SLEEP:       if (wake_req)         st_d = ST_OSC_DELAY;
      default:                              st_d = ST_RESET_DELAY;
    endcase
  end

  always_comb begin
    cnt_clr = rsv || (st_d != st_q) || (st_q == ST_RUN) || (st_q == ST_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET_DELAY;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int SUP_SHORT   = 4096,
  parameter int SUP_LONG    = 65536,
  parameter int OSC_XTAL    = 16,
  parameter int OSC_LF      = 32,
  parameter int OSC_RC      = 6,
  parameter int OSC_EXT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] clk_sel,
  input  logic       long_delay,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       wdt_tick,
  input  logic       osc_tick,
  output logic [2:0] src_id,
  output logic       sel_reserved,
  output logic       run_en
);

  localparam int CW = $clog2(SUP_LONG + 1);

  logic          rst_core_n;
  src_e          src;
  logic          rsv;
  seq_st_e       state;
  logic          cnt_clr;
  logic          cnt_done;
  logic          in_supply;
  logic          tick;
  logic [CW-1:0] sup_tgt;
  logic [CW-1:0] osc_tgt;
  logic [CW-1:0] tgt;

  reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  sel_decode u_dec (
    .code (clk_sel),
    .src  (src),
    .rsv  (rsv)
  );

  always_comb begin
    case (src)
      SRC_XTAL:   osc_tgt = CW'(OSC_XTAL);
      SRC_LFXTAL: osc_tgt = CW'(OSC_LF);
      SRC_RCOSC:  osc_tgt = CW'(OSC_RC);
      SRC_EXTCLK: osc_tgt = CW'(OSC_EXT);
      default:    osc_tgt = CW'(1);
    endcase
  end

  assign sup_tgt   = long_delay ? CW'(SUP_LONG) : CW'(SUP_SHORT);
  assign in_supply = (state == ST_RESET_DELAY);
  assign tgt       = in_supply ? sup_tgt : osc_tgt;
  assign tick      = in_supply ? wdt_tick : osc_tick;

  settle_counter #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (cnt_clr),
    .en     (tick),
    .target (tgt),
    .done   (cnt_done)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rsv       (rsv),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .cnt_done  (cnt_done),
    .state     (state),
    .cnt_clr   (cnt_clr)
  );

  assign src_id       = src;
  assign sel_reserved = rsv;
  assign run_en       = (state == ST_RUN);

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] clk_sel,
  input logic       sleep_req,
  input logic       osc_tick,
  input logic [2:0] src_id,
  input logic       sel_reserved,
  input logic       run_en
);

  assert_xtal_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel[3] |-> (src_id == 3'd1 && !sel_reserved));

  assert_reserved_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reserved |-> (src_id == 3'd0));

  assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(osc_tick));

  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_reserved && !run_en) |=> !run_en);

  assert_sleep_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sleep_req) |=> !run_en);

  assert_run_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sleep_req) |=> run_en);

  assert_reset_blocks_R10: assert property (@(posedge clk)
    !rst_n |-> !run_en);

endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_sel      (clk_sel),
  .sleep_req    (sleep_req),
  .osc_tick     (osc_tick),
  .src_id       (src_id),
  .sel_reserved (sel_reserved),
  .run_en       (run_en)
);

// File: tb/tb_startup_seq.sv
`timescale 1ns/1ps
module tb_startup_seq;

  logic       clk;
  logic       rst_n;
  logic [3:0] clk_sel;
  logic       long_delay;
  logic       sleep_req;
  logic       wake_req;
  logic       wdt_tick;
  logic       osc_tick;
  logic [2:0] src_id;
  logic       sel_reserved;
  logic       run_en;

  int tests;
  int fails;

  // {code[3:0], reserved, src_id[2:0]}
  localparam logic [7:0] VEC [0:15] = '{
    8'h04, 8'h18, 8'h23, 8'h38, 8'h48, 8'h58, 8'h62, 8'h72,
    8'h81, 8'h91, 8'hA1, 8'hB1, 8'hC1, 8'hD1, 8'hE1, 8'hF1
  };

  startup_seq dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .long_delay   (long_delay),
    .sleep_req    (sleep_req),
    .wake_req     (wake_req),
    .wdt_tick     (wdt_tick),
    .osc_tick     (osc_tick),
    .src_id       (src_id),
    .sel_reserved (sel_reserved),
    .run_en       (run_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 run_en low in reset", 32'(run_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wdt_burst(input int n);
    wdt_tick = 1'b1;
    repeat (n) @(negedge clk);
    wdt_tick = 1'b0;
  endtask

  task automatic osc_burst(input int n);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; clk_sel = 4'h0; long_delay = 1'b0;
    sleep_req = 1'b0; wake_req = 1'b0; wdt_tick = 1'b0; osc_tick = 1'b0;

    // decode sweep while held in reset
    @(negedge clk);
    chk("R10 reset state run_en", 32'(run_en), 32'd0);
    for (int i = 0; i < 16; i++) begin
      clk_sel = VEC[i][7:4];
      #1;
      if (VEC[i][3])      chk("R3 reserved decode", {28'd0, sel_reserved, src_id}, 32'(VEC[i][3:0]));
      else if (VEC[i][7]) chk("R1 crystal decode",  {28'd0, sel_reserved, src_id}, 32'(VEC[i][3:0]));
      else                chk("R2 class decode",    {28'd0, sel_reserved, src_id}, 32'(VEC[i][3:0]));
    end
    @(negedge clk);

    // short supply delay, external clock (2 ticks)
    clk_sel = 4'b0000; long_delay = 1'b0;
    do_reset();
    wdt_burst(4095);
    chk("R4 not ready after 4095 wdt", 32'(run_en), 32'd0);
    osc_burst(10);
    chk("R4 osc ticks ignored in supply phase", 32'(run_en), 32'd0);
    wdt_burst(1);
    osc_burst(1);
    chk("R5 ext clk after 1 of 2", 32'(run_en), 32'd0);
    osc_burst(1);
    chk("R5 ext clk run after 2", 32'(run_en), 32'd1);

    // wake ignored in run
    pulse_wake();
    @(negedge clk);
    chk("R9 wake in run ignored", 32'(run_en), 32'd1);

    // sleep, then wake with low-frequency crystal (32 ticks)
    pulse_sleep();
    chk("R7 run_en drops on sleep", 32'(run_en), 32'd0);
    osc_burst(40);
    chk("R7 stays asleep without wake", 32'(run_en), 32'd0);
    clk_sel = 4'b0110;
    pulse_wake();
    osc_burst(31);
    chk("R8 LF after 31 of 32", 32'(run_en), 32'd0);
    osc_burst(1);
    chk("R8 wake run without wdt ticks", 32'(run_en), 32'd1);

    // reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 async drop of run_en", 32'(run_en), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    osc_burst(100);
    chk("R10 restart needs supply delay", 32'(run_en), 32'd0);

    // reserved code holds, then RC (6 ticks) restarts count
    clk_sel = 4'b0011;
    do_reset();
    chk("R6 reserved flag high", 32'(sel_reserved), 32'd1);
    wdt_burst(5000);
    osc_burst(50);
    chk("R6 held while reserved", 32'(run_en), 32'd0);
    clk_sel = 4'b0010;
    wdt_burst(4095);
    osc_burst(10);
    chk("R6 count restarted from zero", 32'(run_en), 32'd0);
    wdt_burst(1);
    osc_burst(5);
    chk("R5 RC after 5 of 6", 32'(run_en), 32'd0);
    osc_burst(1);
    chk("R5 RC run after 6", 32'(run_en), 32'd1);

    // long supply delay, crystal (16 ticks)
    clk_sel = 4'b1000; long_delay = 1'b1;
    do_reset();
    wdt_burst(65535);
    osc_burst(20);
    chk("R4 long delay not done at 65535", 32'(run_en), 32'd0);
    wdt_burst(1);
    osc_burst(15);
    chk("R5 crystal after 15 of 16", 32'(run_en), 32'd0);
    osc_burst(1);
    chk("R5 crystal run after 16", 32'(run_en), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule